// File: doc/BRIEF.md
# Nested Four-Level Interrupt Controller

This block sits beside a small 8-bit CPU core and turns event pulses from the surrounding peripherals into prioritised, vectored interrupt requests. The peripherals are two basic timers, a third timer with overflow and capture/reload events, a UART with separate receive and transmit events, an ADC conversion-done event, a watchdog time-out, a power-fail event and two external pins. Each event sets a pending flag. Each source then passes through its own enable and a global enable. The power-fail source is the exception: it ignores the global enable. Each source carries a two-bit priority level.

A combinational arbiter picks the highest level among live requests and breaks ties with a fixed source order. The winner is granted only if its level is strictly above every level already in service. A grant produces a one-cycle acknowledge together with the source's vector address and level. The granted level is recorded in an active-level set. A return-from-interrupt pulse removes the highest recorded level, and that re-opens arbitration at that level and below. The two external-pin flags and the two basic-timer flags are cleared by hardware when acknowledged. All other flags stay set until software clears them through a write-one-to-clear input.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A pulse on `evt_in[f]` sets `pend_flags[f]` on the next clock edge. The flag then holds until it is cleared. When a set and a clear of the same flag arrive in the same cycle, the set wins. Flag positions are:
  - 0: external pin 0
  - 1: timer 0
  - 2: external pin 1
  - 3: timer 1
  - 4: UART receive
  - 5: UART transmit
  - 6: timer 2 overflow
  - 7: timer 2 capture/reload
  - 8: power-fail
  - 9: ADC done
  - 10: watchdog
- R2: Flags 0 to 3 are cleared at the same edge that raises `irq_ack` for their source. If their event arrives in that same cycle, the flag stays set.
- R3: Flags 4 to 10 are never cleared by an acknowledge. They clear only through `flag_clr`. A flag left set re-requests once arbitration re-opens.
- R4: Source numbers run 0 to 8 in this order, with 0 highest in the tie-break:
  - 0: external pin 0
  - 1: timer 0
  - 2: external pin 1
  - 3: timer 1
  - 4: UART
  - 5: timer 2
  - 6: power-fail
  - 7: ADC
  - 8: watchdog
  Source 4 is pending when flag 4 or flag 5 is set, and source 5 when flag 6 or flag 7 is set. Every other source maps to one flag.
- R5: Source s requests when it is pending and `src_en[s]` is 1. It also needs `glb_en` to be 1, except for source 6 (power-fail), which needs only its own enable.
- R6: The level of source s is `{prio_hi[s], prio_lo[s]}`, from 0 to 3. Among live requests, the highest level is selected, and `irq_lvl` reports it.
- R7: Among requests at the selected level, the lowest source number wins.
- R8: A grant raises `irq_ack` for one cycle, starting one edge after the request is visible. In that same cycle `irq_vec` = 0x0003 + 8·source. `irq_vec` holds between acknowledges.
- R9: A request is granted only if its level is above every bit set in `active_lvls`. A grant sets bit `irq_lvl` of `active_lvls`.
- R10: A `reti` pulse clears the highest set bit of `active_lvls`. No grant is made in a cycle in which `reti` is high.
- R11: While `rst_n` is low at a clock edge, all flags, `active_lvls`, `irq_ack`, `irq_vec` and `irq_lvl` return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 11 | One-cycle event pulses, one per flag |
| flag_clr | input | 11 | Write-one-to-clear pulses, one per flag |
| src_en | input | 9 | Per-source enables |
| glb_en | input | 1 | Global enable (ignored by power-fail) |
| prio_hi | input | 9 | Upper priority bit per source |
| prio_lo | input | 9 | Lower priority bit per source |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_ack | output | 1 | Grant pulse |
| irq_vec | output | 16 | Vector address of the last grant |
| irq_lvl | output | 2 | Level of the last grant |
| pend_flags | output | 11 | Pending flags |
| active_lvls | output | 4 | Levels currently in service |

## Verification
The hardest state to reach is a three-deep situation. A low-level service is running. A same-level request and a lower-level request are both held back behind it. Then a higher-level request preempts the running service. Reaching this from the ports takes a fixed sequence: programme the levels, pulse three events at once, and confirm that only the tie-break winner is acknowledged. Next, inject the top-level event and check the preemption. Then issue `reti` pulses one at a time and check that the blocked requests come out in level order. Long random phases with frequent `reti`, clears and re-programmed priorities are compared against a reference model every cycle.

// File: rtl/irqc_pkg.sv
// Shared constants and the flag-to-source mapping of the interrupt controller.
// Assumes the fixed set of eleven flags and nine sources described in the brief.
package irqc_pkg;
    localparam int NUM_FLAGS    = 11;
    localparam int NUM_SRC      = 9;
    localparam int LVL_W        = 2;
    localparam int NUM_LVL      = 1 << LVL_W;
    localparam int SRC_W        = $clog2(NUM_SRC);
    localparam int SRC_PFAIL    = 6;
    localparam int HW_CLR_SRCS  = 4;   // sources below this number clear on acknowledge

    // Source number that a flag feeds; UART and timer 2 own two flags each.
    function automatic int flag_to_src(input int f);
        if (f < 4)      return f;
        else if (f < 6) return 4;
        else if (f < 8) return 5;
        else            return f - 2;
    endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
// Pending-flag storage. Each flag is set by its event pulse, which beats any
// clear in the same cycle. Flags of the lowest-numbered sources are cleared
// when their source is granted; all flags accept a software clear pulse.
// Assumes grant_src is meaningful only while grant is high.
module irqc_flag_bank
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt,
    input  logic [NUM_FLAGS-1:0] clr,
    input  logic                 grant,
    input  logic [SRC_W-1:0]     grant_src,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_SRC-1:0]   pend
);
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        localparam int SRC = flag_to_src(f);
        localparam bit HWC = (SRC < HW_CLR_SRCS);
        logic flag_q;
        logic hw_clr;

        assign hw_clr = HWC && grant && (grant_src == SRC_W'(SRC));

        // Set on event, else clear by software or by the acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                flag_q <= 1'b0;
            else if (evt[f])           flag_q <= 1'b1;
            else if (clr[f] || hw_clr) flag_q <= 1'b0;
        end

        assign flags[f] = flag_q;
    end

    // Fold the flags into one pending bit per source.
    always_comb begin
        pend = '0;
        for (int f = 0; f < NUM_FLAGS; f++) begin
            pend[flag_to_src(f)] = pend[flag_to_src(f)] | flags[f];
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Combinational request gating and selection. Finds the highest level among
// live requests, picks the lowest source number at that level and grants it
// only when that level is above every level in service and no return pulse
// is present. Assumes act_mask holds one bit per level.
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] prio_hi,
    input  logic [NUM_SRC-1:0] prio_lo,
    input  logic [NUM_LVL-1:0] act_mask,
    input  logic               reti,
    output logic               grant,
    output logic [SRC_W-1:0]   win_src,
    output logic [LVL_W-1:0]   win_lvl
);
    logic [NUM_SRC-1:0] req;
    logic [LVL_W-1:0]   lvl_of [NUM_SRC];
    logic [NUM_LVL-1:0] lvl_hit;
    logic               any_req;
    logic               blocked;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam bit NO_GLOBAL = (s == SRC_PFAIL);
        assign req[s]    = pend[s] & src_en[s] & (glb_en | NO_GLOBAL);
        assign lvl_of[s] = {prio_hi[s], prio_lo[s]};
    end

    // Mark which levels carry at least one live request.
    always_comb begin
        for (int l = 0; l < NUM_LVL; l++) begin
            lvl_hit[l] = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (req[s] && (lvl_of[s] == LVL_W'(l))) lvl_hit[l] = 1'b1;
            end
        end
    end

    // Highest requested level; the ascending scan leaves the top one.
    always_comb begin
        win_lvl = '0;
        any_req = 1'b0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_hit[l]) begin
                win_lvl = LVL_W'(l);
                any_req = 1'b1;
            end
        end
    end

    // Lowest source number at the chosen level; the descending scan leaves it.
    always_comb begin
        win_src = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (req[s] && (lvl_of[s] == win_lvl)) win_src = SRC_W'(s);
        end
    end

    // Grant only above every level in service and never beside a return.
    always_comb begin
        blocked = |(act_mask >> win_lvl);
        grant   = any_req & ~blocked & ~reti;
    end
endmodule

// File: rtl/irqc_nest_stack.sv
// Set of levels in service. A push marks the granted level; a pop clears the
// highest marked level. Assumes push and pop never occur in the same cycle,
// which the arbiter guarantees.
module irqc_nest_stack
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [LVL_W-1:0]   push_lvl,
    input  logic               pop,
    output logic [NUM_LVL-1:0] act_mask
);
    logic [NUM_LVL-1:0] pop_sel;
    logic [NUM_LVL-1:0] push_sel;

    // One-hot of the highest level in service.
    always_comb begin
        pop_sel = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (act_mask[l]) begin
                pop_sel    = '0;
                pop_sel[l] = 1'b1;
            end
        end
    end

    // One-hot of the level being entered.
    always_comb begin
        push_sel = '0;
        if (push) push_sel[push_lvl] = 1'b1;
    end

    // Apply pop then push to the level set.
    always_ff @(posedge clk) begin
        if (!rst_n) act_mask <= '0;
        else        act_mask <= (act_mask & ~(pop ? pop_sel : '0)) | push_sel;
    end
endmodule

// File: rtl/nested_irq_ctrl.sv
// Top of the nested four-level interrupt controller. Connects the flag bank,
// the arbiter and the level set, and registers the acknowledge, vector and
// level of each grant. Assumes single-cycle event, clear and return pulses
// that are synchronous to clk.
module nested_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt_in,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic [NUM_SRC-1:0]   src_en,
    input  logic                 glb_en,
    input  logic [NUM_SRC-1:0]   prio_hi,
    input  logic [NUM_SRC-1:0]   prio_lo,
    input  logic                 reti,
    output logic                 irq_ack,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [LVL_W-1:0]     irq_lvl,
    output logic [NUM_FLAGS-1:0] pend_flags,
    output logic [NUM_LVL-1:0]   active_lvls
);
    logic [NUM_SRC-1:0] pend;
    logic               grant;
    logic [SRC_W-1:0]   win_src;
    logic [LVL_W-1:0]   win_lvl;
    logic [VEC_W-1:0]   vec_n;

    irqc_flag_bank u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_in),
        .clr       (flag_clr),
        .grant     (grant),
        .grant_src (win_src),
        .flags     (pend_flags),
        .pend      (pend)
    );

    irqc_arbiter u_arb (
        .pend     (pend),
        .src_en   (src_en),
        .glb_en   (glb_en),
        .prio_hi  (prio_hi),
        .prio_lo  (prio_lo),
        .act_mask (active_lvls),
        .reti     (reti),
        .grant    (grant),
        .win_src  (win_src),
        .win_lvl  (win_lvl)
    );

    irqc_nest_stack u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (grant),
        .push_lvl (win_lvl),
        .pop      (reti),
        .act_mask (active_lvls)
    );

    assign vec_n = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win_src);

    // Register the grant pulse and hold vector and level between grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ack <= 1'b0;
            irq_vec <= '0;
            irq_lvl <= '0;
        end else begin
            irq_ack <= grant;
            if (grant) begin
                irq_vec <= vec_n;
                irq_lvl <= win_lvl;
            end
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Property checker for nested_irq_ctrl, attached by bind. Observes ports only.
module irqc_checker #(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [10:0]      evt_in,
    input logic [10:0]      flag_clr,
    input logic             reti,
    input logic             irq_ack,
    input logic [VEC_W-1:0] irq_vec,
    input logic [1:0]       irq_lvl,
    input logic [10:0]      pend_flags,
    input logic [3:0]       active_lvls
);
    logic past_ok;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    p_ack_marks_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> active_lvls[irq_lvl]);

    p_ack_is_top_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ((active_lvls >> irq_lvl) == 4'd1));

    p_vec_on_grid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ((irq_vec >= VEC_W'(VEC_BASE)) &&
                     (((irq_vec - VEC_W'(VEC_BASE)) % VEC_W'(VEC_STEP)) == '0) &&
                     (irq_vec <= VEC_W'(VEC_BASE + 8 * VEC_STEP))));

    p_no_grant_on_reti_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq_ack);

    p_reti_pops_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(reti) && ($past(active_lvls) != 4'd0)) |->
        ($countones(active_lvls) + 1 == $countones($past(active_lvls))));

    p_timer0_hw_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_ack && (irq_vec == VEC_W'(VEC_BASE + VEC_STEP)) && !$past(evt_in[1]))
        |-> !pend_flags[1]);

    p_uart_flag_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_ack && (irq_vec == VEC_W'(VEC_BASE + 4 * VEC_STEP)) &&
         $past(pend_flags[4]) && !$past(flag_clr[4])) |-> pend_flags[4]);
endmodule

bind nested_irq_ctrl irqc_checker #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_in      (evt_in),
    .flag_clr    (flag_clr),
    .reti        (reti),
    .irq_ack     (irq_ack),
    .irq_vec     (irq_vec),
    .irq_lvl     (irq_lvl),
    .pend_flags  (pend_flags),
    .active_lvls (active_lvls)
);

// File: tb/nested_irq_ctrl_tb.sv
// Self-checking bench: directed scenarios plus a random phase, with a
// behavioural reference model compared on every clock.
module nested_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt = '0, clr = '0;
    logic [8:0]  en = '0, hi = '0, lo = '0;
    logic        glb = 1'b0, reti = 1'b0;
    logic        irq_ack;
    logic [15:0] irq_vec;
    logic [1:0]  irq_lvl;
    logic [10:0] pend_flags;
    logic [3:0]  active_lvls;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    nested_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .flag_clr(clr), .src_en(en),
        .glb_en(glb), .prio_hi(hi), .prio_lo(lo), .reti(reti), .irq_ack(irq_ack),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .pend_flags(pend_flags),
        .active_lvls(active_lvls)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [10:0] m_flags;
    int          stk[$];
    logic        m_ack;
    logic [15:0] m_vec;
    logic [1:0]  m_lvl;

    function automatic int m_src_of(input int f);
        case (f)
            0, 1, 2, 3: return f;
            4, 5:       return 4;
            6, 7:       return 5;
            default:    return f - 2;
        endcase
    endfunction

    function automatic logic [3:0] m_mask();
        logic [3:0] m = '0;
        foreach (stk[i]) m[stk[i]] = 1'b1;
        return m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0; stk.delete(); m_ack = 1'b0; m_vec = '0; m_lvl = '0;
        end else begin
            int best, blvl, cur;
            bit g;
            best = -1; blvl = -1;
            for (int s = 0; s < 9; s++) begin
                bit p;
                int lv;
                p = 1'b0;
                for (int f = 0; f < 11; f++) if (m_src_of(f) == s && m_flags[f]) p = 1'b1;
                lv = hi[s] * 2 + lo[s];
                if (p && en[s] && (glb || s == 6) && lv > blvl) begin
                    best = s; blvl = lv;
                end
            end
            cur = (stk.size() > 0) ? stk[stk.size()-1] : -1;
            g = (best >= 0) && !reti && (blvl > cur);
            for (int f = 0; f < 11; f++) begin
                if (evt[f]) m_flags[f] = 1'b1;
                else if (clr[f]) m_flags[f] = 1'b0;
                else if (g && m_src_of(f) == best && best < 4) m_flags[f] = 1'b0;
            end
            if (reti && stk.size() > 0) void'(stk.pop_back());
            if (g) begin
                stk.push_back(blvl);
                m_vec = 16'(3 + 8 * best);
                m_lvl = 2'(blvl);
            end
            m_ack = g;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pend_flags === m_flags, "R1 model flags", 32'(pend_flags), 32'(m_flags));
            chk(irq_ack === m_ack, "R8 model ack", 32'(irq_ack), 32'(m_ack));
            chk(irq_vec === m_vec, "R8 model vector", 32'(irq_vec), 32'(m_vec));
            chk(active_lvls === m_mask(), "R9 model levels", 32'(active_lvls), 32'(m_mask()));
            if (m_ack) chk(irq_lvl === m_lvl, "R6 model level", 32'(irq_lvl), 32'(m_lvl));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(); @(negedge clk); endtask
    task automatic pulse(input logic [10:0] v); evt = v; tick(); evt = '0; endtask
    task automatic wclr(input logic [10:0] v); clr = v; tick(); clr = '0; endtask
    task automatic do_reti(); reti = 1'b1; tick(); reti = 1'b0; endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk(pend_flags == 0 && irq_ack == 0 && irq_vec == 0 && active_lvls == 0,
            "R11 reset state", {pend_flags, irq_ack, irq_vec, active_lvls}, 0);

        en = '1; glb = 1'b1; tick();

        // Timer 0: set, grant, hardware clear, single pulse, return.
        pulse(11'b1 << 1);
        chk(pend_flags[1] == 1'b1, "R1 flag set", 32'(pend_flags), 32'h2);
        tick();
        chk(irq_ack && irq_vec == 16'h000B, "R8 timer0 vector", 32'(irq_vec), 32'h000B);
        chk(pend_flags[1] == 1'b0, "R2 hardware clear", 32'(pend_flags), 0);
        chk(active_lvls == 4'b0001, "R9 level pushed", 32'(active_lvls), 1);
        tick();
        chk(irq_ack == 1'b0, "R8 single-cycle ack", 32'(irq_ack), 0);
        do_reti();
        chk(active_lvls == 4'b0000, "R10 level popped", 32'(active_lvls), 0);

        // UART transmit: shared source, flag survives the acknowledge.
        pulse(11'b1 << 5);
        tick();
        chk(irq_ack && irq_vec == 16'h0023, "R4 UART vector", 32'(irq_vec), 32'h0023);
        chk(pend_flags[5] == 1'b1, "R3 flag kept on ack", 32'(pend_flags), 32'h20);
        repeat (3) tick();
        chk(!irq_ack && active_lvls == 4'b0001, "R9 same level blocked", 32'(active_lvls), 1);
        do_reti();
        tick();
        chk(irq_ack && irq_vec == 16'h0023, "R3 re-request after return", 32'(irq_vec), 32'h0023);
        wclr(11'b1 << 5);
        do_reti();
        repeat (2) tick();
        chk(!irq_ack && active_lvls == 0 && pend_flags == 0, "R3 software clear", 32'(pend_flags), 0);

        // Set beats clear in the same cycle.
        en[7] = 1'b0;
        evt = 11'b1 << 9; clr = 11'b1 << 9; tick(); evt = '0; clr = '0;
        chk(pend_flags[9] == 1'b1, "R1 set wins over clear", 32'(pend_flags), 32'h200);
        wclr(11'b1 << 9);
        chk(pend_flags[9] == 1'b0, "R1 clear", 32'(pend_flags), 0);
        en[7] = 1'b1;

        // Global enable off: power-fail still granted, external 0 held back.
        glb = 1'b0;
        pulse(11'b1 | (11'b1 << 8));
        tick();
        chk(irq_ack && irq_vec == 16'h0033, "R5 power-fail bypasses global", 32'(irq_vec), 32'h0033);
        wclr(11'b1 << 8);
        do_reti();
        repeat (3) tick();
        chk(!irq_ack && active_lvls == 0 && pend_flags[0], "R5 global gate", 32'(irq_ack), 0);
        glb = 1'b1;
        tick();
        chk(irq_ack && irq_vec == 16'h0003, "R5 released by global", 32'(irq_vec), 32'h0003);
        chk(pend_flags[0] == 1'b0, "R2 external 0 cleared", 32'(pend_flags), 0);
        do_reti();

        // Levels: timer0/timer1 at 2, external 1 at 1, ADC at 3.
        hi = 9'b0_1000_1010; lo = 9'b0_1000_0100; tick();
        pulse(11'b1110);
        tick();
        chk(irq_ack && irq_vec == 16'h000B && irq_lvl == 2, "R7 tie-break", 32'(irq_vec), 32'h000B);
        repeat (2) tick();
        chk(!irq_ack && active_lvls == 4'b0100, "R9 equal and lower blocked", 32'(active_lvls), 4);
        pulse(11'b1 << 9);
        tick();
        chk(irq_ack && irq_vec == 16'h003B && irq_lvl == 3, "R6 preemption", 32'(irq_vec), 32'h003B);
        chk(active_lvls == 4'b1100, "R9 nested levels", 32'(active_lvls), 32'hC);
        wclr(11'b1 << 9);
        do_reti();
        chk(active_lvls == 4'b0100, "R10 highest popped", 32'(active_lvls), 4);
        do_reti();
        tick();
        chk(irq_ack && irq_vec == 16'h001B && irq_lvl == 2, "R7 timer1 next", 32'(irq_vec), 32'h001B);
        do_reti();
        tick();
        chk(irq_ack && irq_vec == 16'h0013 && irq_lvl == 1, "R6 lower level last", 32'(irq_vec), 32'h0013);
        do_reti();
        hi = '0; lo = '0;

        // Timer 2 capture flag feeds source 5.
        pulse(11'b1 << 7);
        tick();
        chk(irq_ack && irq_vec == 16'h002B, "R4 timer2 capture", 32'(irq_vec), 32'h002B);
        wclr(11'b1 << 7);
        do_reti();

        // Watchdog needs its own enable.
        en[8] = 1'b0;
        pulse(11'b1 << 10);
        repeat (3) tick();
        chk(!irq_ack && pend_flags[10], "R5 watchdog enable", 32'(irq_ack), 0);
        en[8] = 1'b1;
        tick();
        chk(irq_ack && irq_vec == 16'h0043, "R8 watchdog vector", 32'(irq_vec), 32'h0043);
        wclr(11'b1 << 10);
        do_reti();

        // Random phase, checked against the model.
        for (int c = 0; c < 4000; c++) begin
            if (c % 200 == 0) begin
                en = 9'($urandom); hi = 9'($urandom); lo = 9'($urandom);
                glb = ($urandom % 4) != 0;
            end
            evt  = ($urandom % 6 == 0) ? (11'($urandom) & 11'($urandom)) : '0;
            clr  = ($urandom % 5 == 0) ? (11'($urandom) & 11'($urandom)) : '0;
            reti = ($urandom % 4 == 0);
            tick();
        end
        evt = '0; clr = '0; reti = 1'b0;
        repeat (3) tick();

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule